// File: doc/BRIEF.md
# Serial-Bus Receive Packet Capture

This block sits on the link side of a serial-bus physical layer and watches the 2-bit status bus and the 4-bit nibble bus that the physical layer drives toward the link. When the status bus reports Receive, the block skips the all-ones filler, takes the first other nibble as the speed code, and reports the decoded data rate. The speed code is dropped and is never treated as packet data. Every nibble that follows is packed into a 32-bit word, most significant nibble first.

Completed words go through a small buffer to a valid/ready output. Each word carries a start marker, an end marker, a count of valid bytes and an error code. Reception ends as soon as the status bus leaves Receive. A partial last word is then flushed, left-aligned, together with its byte count. Reception that stops before a speed code leaves no trace. Reception that stops after the speed code but before any data produces a single error item. An unknown speed code also produces a single error item, and the block ignores the rest of that packet. When the buffer is full, further words are dropped and a sticky flag is raised until it is cleared.

Top module: `phy_rx_capture`

## Requirements
- R1: After reset, outValid, rateValid and ovfFlag are all 0.
- R2: While phyCtl is Receive (2'b10) and no speed code has been seen yet, the value 4'b1111 on phyData is filler. Neither the filler nor the speed code itself appears in any output word.
- R3: A speed code whose two upper bits are 00 selects 100 Mbit/s, whatever its two lower bits are. From the cycle after the speed code until reception ends, rateValid is 1 and rateHigh is 0.
- R4: The speed code 4'b0100 selects 200 Mbit/s. rateValid is 1 and rateHigh is 1 until reception ends.
- R5: Payload nibbles fill each 32-bit word from bit 31 downward. A full word has outBytes = 4. The first word of a packet has outSop = 1, the last word has outEop = 1, and outErr = 2'b00 on every data word.
- R6: If reception ends partway through a word, that word is output left-aligned with zeros in the unused nibbles. Its outBytes is ceil(nibbles/2), and outEop = 1.
- R7: If phyCtl leaves Receive before any speed code has arrived, no output item is produced.
- R8: If phyCtl leaves Receive after a valid speed code but before any payload nibble, exactly one item is produced, with outSop = outEop = 1, outBytes = 0, outData = 0 and outErr = 2'b01.
- R9: A speed code that is neither 00xx nor 0100 produces exactly one item, with outSop = outEop = 1, outBytes = 0, outData = 0 and outErr = 2'b10. Every later nibble of that reception is discarded.
- R10: Any phyCtl value other than 2'b10 ends reception, and the end is handled the same way whichever non-Receive value ends it.
- R11: While outValid is 1 and outReady is 0, outValid stays 1 and the output fields stay stable. At least two words can be held with no loss while outReady is low.
- R12: A word produced while the buffer is full is dropped and sets ovfFlag. ovfFlag stays set until ovfClear is 1 for a cycle. Words already in the buffer still leave in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| phyCtl | input | 2 | Status bus from the physical layer (2'b10 Receive, 2'b00 Idle) |
| phyData | input | 4 | Nibble bus from the physical layer |
| outReady | input | 1 | Downstream accepts the current item |
| ovfClear | input | 1 | Clears the sticky overflow flag |
| outValid | output | 1 | An item is presented |
| outData | output | 32 | Packed payload word, first nibble in bits 31:28 |
| outSop | output | 1 | First item of a packet |
| outEop | output | 1 | Last item of a packet |
| outBytes | output | 3 | Valid bytes in outData (0 to 4) |
| outErr | output | 2 | 00 ok, 01 empty packet, 10 unknown speed |
| rateValid | output | 1 | A good speed code is in force for the current reception |
| rateHigh | output | 1 | 0 means 100 Mbit/s, 1 means 200 Mbit/s |
| ovfFlag | output | 1 | Sticky buffer overflow flag |

## Verification
Assertions check the following on every cycle: the buffer never holds more than its depth, an item waiting on a stalled output stays unchanged, the overflow flag stays set until cleared and rises on every dropped word, the control asserts at most one datapath strobe per cycle, and filler is never taken as a speed code. Other behaviours depend on the data values the bench chooses, so only its scenarios can show them: nibble ordering inside a word, byte counts for partial words, the decoding of each speed code, the silent drop on an early end, the two kinds of error item, and which words survive an overflow.

// File: rtl/phy_rx_pkg.sv
package phy_rx_pkg;
  localparam logic [1:0] CTL_RECV = 2'b10;
  localparam logic [3:0] NIB_FILL = 4'b1111;
  localparam logic [3:0] SPD_HIGH = 4'b0100;

  localparam logic [1:0] ERR_NONE  = 2'b00;
  localparam logic [1:0] ERR_EMPTY = 2'b01;
  localparam logic [1:0] ERR_SPEED = 2'b10;

  // strobes from the control to the datapath, at most one set per cycle
  typedef struct packed {
    logic startPkt;
    logic nibbleEn;
    logic flushEnd;
    logic errEmpty;
    logic errSpeed;
  } rxStrobeT;
endpackage

// File: rtl/phy_rx_ctl.sv
module phy_rx_ctl
  import phy_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] ctlIn,
  input  logic [3:0] dataIn,
  input  logic       hasData,
  output rxStrobeT   strb,
  output logic       rateValid,
  output logic       rateHigh
);
  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_PAY, ST_DROP} stateT;
  stateT stateQ, stateD;
  logic rateHighQ, rateHighD;

  logic isRecv, isFill, spdLow, spdHigh;
  assign isRecv  = (ctlIn == CTL_RECV);
  assign isFill  = (dataIn == NIB_FILL);
  assign spdLow  = (dataIn[3:2] == 2'b00);
  assign spdHigh = (dataIn == SPD_HIGH);

  always_comb begin
    stateD    = stateQ;
    rateHighD = rateHighQ;
    strb      = '0;
    unique case (stateQ)
      ST_IDLE, ST_HUNT: begin
        if (!isRecv) begin
          stateD = ST_IDLE;
        end else if (isFill) begin
          stateD = ST_HUNT;
        end else if (spdLow || spdHigh) begin
          stateD        = ST_PAY;
          strb.startPkt = 1'b1;
          rateHighD     = spdHigh;
        end else begin
          stateD        = ST_DROP;
          strb.errSpeed = 1'b1;
        end
      end
      ST_PAY: begin
        if (isRecv) begin
          strb.nibbleEn = 1'b1;
        end else begin
          stateD = ST_IDLE;
          if (hasData) strb.flushEnd = 1'b1;
          else         strb.errEmpty = 1'b1;
        end
      end
      ST_DROP: begin
        if (!isRecv) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      rateHighQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      rateHighQ <= rateHighD;
    end
  end

  assign rateValid = (stateQ == ST_PAY);
  assign rateHigh  = rateHighQ;

  AST_FILL_NOT_SPEED: assert property (@(posedge clk) disable iff (!rstN)
    strb.startPkt |-> (dataIn != NIB_FILL)) else $error("filler taken as speed"); // R2
endmodule

// File: rtl/phy_rx_pack.sv
module phy_rx_pack
  import phy_rx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobeT          strb,
  input  logic [3:0]        dataIn,
  output logic              hasData,
  output logic              pushEn,
  output logic [WORD_W-1:0] pushData,
  output logic              pushSop,
  output logic              pushEop,
  output logic [BYTE_W-1:0] pushBytes,
  output logic [1:0]        pushErr
);
  localparam int NIB_W = 4;
  localparam int NIBS  = WORD_W / NIB_W;
  localparam int CNT_W = $clog2(NIBS + 1);
  localparam int SH_W  = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] accQ;
  logic [CNT_W-1:0]  cntQ;
  logic              sopPendQ;
  logic              fullWord;
  logic [SH_W-1:0]   alignSh;

  assign fullWord = (cntQ == CNT_W'(NIBS));
  assign hasData  = (cntQ != '0) || !sopPendQ;
  assign alignSh  = SH_W'((NIBS - int'(cntQ)) * NIB_W);

  always_comb begin
    pushEn    = 1'b0;
    pushData  = '0;
    pushSop   = 1'b0;
    pushEop   = 1'b0;
    pushBytes = '0;
    pushErr   = ERR_NONE;
    if (strb.errSpeed || strb.errEmpty) begin
      pushEn  = 1'b1;
      pushSop = 1'b1;
      pushEop = 1'b1;
      pushErr = strb.errSpeed ? ERR_SPEED : ERR_EMPTY;
    end else if (strb.nibbleEn && fullWord) begin
      pushEn    = 1'b1;
      pushData  = accQ;
      pushSop   = sopPendQ;
      pushBytes = BYTE_W'(WORD_W / 8);
    end else if (strb.flushEnd) begin
      pushEn    = 1'b1;
      pushData  = accQ << alignSh;
      pushSop   = sopPendQ;
      pushEop   = 1'b1;
      pushBytes = BYTE_W'((int'(cntQ) + 1) / 2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ     <= '0;
      cntQ     <= '0;
      sopPendQ <= 1'b0;
    end else if (strb.startPkt) begin
      accQ     <= '0;
      cntQ     <= '0;
      sopPendQ <= 1'b1;
    end else if (strb.nibbleEn) begin
      accQ <= {accQ[WORD_W-NIB_W-1:0], dataIn};
      if (fullWord) begin
        cntQ     <= CNT_W'(1);
        sopPendQ <= 1'b0;
      end else begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end else if (strb.flushEnd) begin
      accQ <= '0;
      cntQ <= '0;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.startPkt, strb.nibbleEn, strb.flushEnd, strb.errEmpty, strb.errSpeed}))
    else $error("several strobes"); // R9
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_W'(NIBS)) else $error("nibble count range"); // R5
  AST_FLUSH_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushEnd |-> (cntQ != '0)) else $error("flush of empty word"); // R6
endmodule

// File: rtl/phy_rx_fifo.sv
module phy_rx_fifo #(
  parameter int DATA_W = 39,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReady,
  input  logic              ovfClear,
  output logic              valid,
  output logic [DATA_W-1:0] popData,
  output logic              ovfFlag
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     count;
  logic              full, doPop, doPush, dropNow;

  assign full    = (count == CW'(DEPTH));
  assign valid   = (count != '0);
  assign doPop   = valid && popReady;
  assign doPush  = push && (!full || doPop);
  assign dropNow = push && full && !doPop;
  assign popData = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + CW'(1);
      else if (doPop && !doPush) count <= count - CW'(1);
      if (dropNow)       ovfFlag <= 1'b1;
      else if (ovfClear) ovfFlag <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)) else $error("buffer count beyond depth"); // R12
  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    valid && !popReady |=> valid && $stable(popData)) else $error("stalled item changed"); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !ovfClear |=> ovfFlag) else $error("overflow flag lost"); // R12
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    push && full && !popReady |=> ovfFlag) else $error("drop without flag"); // R12
endmodule

// File: rtl/phy_rx_capture.sv
module phy_rx_capture
  import phy_rx_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [1:0]                      phyCtl,
  input  logic [3:0]                      phyData,
  input  logic                            outReady,
  input  logic                            ovfClear,
  output logic                            outValid,
  output logic [WORD_W-1:0]               outData,
  output logic                            outSop,
  output logic                            outEop,
  output logic [$clog2(WORD_W/8+1)-1:0]   outBytes,
  output logic [1:0]                      outErr,
  output logic                            rateValid,
  output logic                            rateHigh,
  output logic                            ovfFlag
);
  localparam int BYTE_W = $clog2(WORD_W / 8 + 1);
  localparam int ITEM_W = WORD_W + BYTE_W + 4;

  rxStrobeT          strb;
  logic              hasData, pushEn, pushSop, pushEop;
  logic [WORD_W-1:0] pushData;
  logic [BYTE_W-1:0] pushBytes;
  logic [1:0]        pushErr;
  logic [ITEM_W-1:0] pushItem, popItem;

  phy_rx_ctl i_ctl (
    .clk(clk), .rstN(rstN), .ctlIn(phyCtl), .dataIn(phyData),
    .hasData(hasData), .strb(strb), .rateValid(rateValid), .rateHigh(rateHigh)
  );

  phy_rx_pack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_pack (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(phyData), .hasData(hasData),
    .pushEn(pushEn), .pushData(pushData), .pushSop(pushSop), .pushEop(pushEop),
    .pushBytes(pushBytes), .pushErr(pushErr)
  );

  assign pushItem = {pushErr, pushBytes, pushEop, pushSop, pushData};

  phy_rx_fifo #(.DATA_W(ITEM_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rstN(rstN), .push(pushEn), .pushData(pushItem),
    .popReady(outReady), .ovfClear(ovfClear), .valid(outValid),
    .popData(popItem), .ovfFlag(ovfFlag)
  );

  assign {outErr, outBytes, outEop, outSop, outData} = popItem;
endmodule

// File: tb/test_phy_rx_capture.sv
module test_phy_rx_capture;
  logic        clk = 1'b0;
  logic        rstN, outReady, ovfClear;
  logic [1:0]  phyCtl;
  logic [3:0]  phyData;
  logic        outValid, outSop, outEop, rateValid, rateHigh, ovfFlag;
  logic [31:0] outData;
  logic [2:0]  outBytes;
  logic [1:0]  outErr;

  always #5 clk = ~clk;

  phy_rx_capture i_phy_rx_capture (
    .clk(clk), .rstN(rstN), .phyCtl(phyCtl), .phyData(phyData),
    .outReady(outReady), .ovfClear(ovfClear), .outValid(outValid),
    .outData(outData), .outSop(outSop), .outEop(outEop), .outBytes(outBytes),
    .outErr(outErr), .rateValid(rateValid), .rateHigh(rateHigh), .ovfFlag(ovfFlag)
  );

  typedef struct packed {
    logic [1:0]  err;
    logic [2:0]  bytes;
    logic        eop;
    logic        sop;
    logic [31:0] data;
  } itemT;

  itemT expQ[$];
  itemT gotItem, expItem;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: compares every accepted item with the head of the scoreboard (R2 R5 R6 R8 R9)
  always @(negedge clk) begin
    if (rstN && outValid && outReady && !finished) begin
      gotItem = {outErr, outBytes, outEop, outSop, outData};
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected item actual %h expected none", gotItem);
      end else begin
        expItem = expQ.pop_front();
        if (gotItem !== expItem) begin
          errors++;
          $display("FAIL R5 item mismatch actual %h expected %h", gotItem, expItem);
        end
      end
    end
  end

  function automatic logic [3:0] nibOf(input int i, input int seed);
    return 4'((i * 5 + seed * 3 + 1) % 16);
  endfunction

  task automatic step(input logic [1:0] c, input logic [3:0] d);
    phyCtl  = c;
    phyData = d;
    @(posedge clk);
    #1;
  endtask

  task automatic sendPacket(input logic [3:0] spd, input int n, input int seed,
                            input logic [1:0] endCtl, input int maxItems);
    bit goodSpd;
    bit high;
    int words;
    itemT it;
    goodSpd = (spd[3:2] == 2'b00) || (spd == 4'b0100);
    high    = (spd == 4'b0100);
    if (!goodSpd) begin
      it = '{err: 2'b10, bytes: 3'd0, eop: 1'b1, sop: 1'b1, data: 32'h0};   // R9
      expQ.push_back(it);
    end else if (n == 0) begin
      it = '{err: 2'b01, bytes: 3'd0, eop: 1'b1, sop: 1'b1, data: 32'h0};   // R8
      expQ.push_back(it);
    end else begin
      words = (n + 7) / 8;
      for (int w = 0; w < words && w < maxItems; w++) begin
        int cnt;
        cnt = (n - 8 * w > 8) ? 8 : n - 8 * w;
        it = '0;
        for (int k = 0; k < cnt; k++) it.data[31 - 4 * k -: 4] = nibOf(8 * w + k, seed);
        it.bytes = 3'((cnt + 1) / 2);
        it.sop   = (w == 0);
        it.eop   = (w == words - 1);
        expQ.push_back(it);
      end
    end
    // R2: filler nibbles then the speed code, neither of which may be captured
    step(2'b10, 4'hF);
    step(2'b10, 4'hF);
    step(2'b10, spd);
    if (goodSpd) begin
      check(rateValid == 1'b1, high ? "R4" : "R3", "rateValid", rateValid, 1);
      check(rateHigh == high, high ? "R4" : "R3", "rateHigh", rateHigh, high);
    end
    for (int i = 0; i < n; i++) step(2'b10, nibOf(i, seed));
    step(endCtl, 4'h0);
    if (goodSpd) check(rateValid == 1'b0, "R10", "rateValid after end", rateValid, 0);
    step(2'b00, 4'h0);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 200 && expQ.size() != 0; i++) @(posedge clk);
    #1;
    repeat (3) @(posedge clk);
    #1;
    check(expQ.size() == 0, req, "scoreboard drained", expQ.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; outReady = 1'b1; ovfClear = 1'b0; phyCtl = 2'b00; phyData = 4'h0;
    repeat (4) @(posedge clk);
    #1;
    check(outValid == 1'b0, "R1", "outValid at reset", outValid, 0);
    check(rateValid == 1'b0, "R1", "rateValid at reset", rateValid, 0);
    check(ovfFlag == 1'b0, "R1", "ovfFlag at reset", ovfFlag, 0);
    rstN = 1'b1;
    step(2'b00, 4'h0);

    // R3 R5: 100 Mbit/s, two full words
    sendPacket(4'b0000, 16, 1, 2'b00, 99);
    drain("R5");
    // R3 R6: low speed bits ignored, partial word of five nibbles
    sendPacket(4'b0011, 5, 2, 2'b00, 99);
    drain("R6");
    // R4: 200 Mbit/s, one and a half words
    sendPacket(4'b0100, 12, 3, 2'b00, 99);
    drain("R4");
    // R6: single nibble, and exactly one full word
    sendPacket(4'b0001, 1, 4, 2'b00, 99);
    sendPacket(4'b0100, 8, 5, 2'b00, 99);
    drain("R6");

    // R7: end before any speed code leaves nothing
    step(2'b10, 4'hF);
    step(2'b10, 4'hF);
    step(2'b10, 4'hF);
    step(2'b00, 4'h0);
    repeat (8) step(2'b00, 4'h0);
    check(outValid == 1'b0, "R7", "outValid after early end", outValid, 0);
    check(rateValid == 1'b0, "R7", "rateValid after early end", rateValid, 0);

    // R8: speed code then immediate end
    sendPacket(4'b0100, 0, 6, 2'b00, 99);
    drain("R8");
    // R9: unknown speed codes; following nibbles discarded
    sendPacket(4'b1000, 6, 7, 2'b00, 99);
    sendPacket(4'b0101, 9, 8, 2'b00, 99);
    drain("R9");
    check(rateValid == 1'b0, "R9", "rateValid after bad speed", rateValid, 0);

    // R10: a non-Receive, non-Idle status also ends the packet
    sendPacket(4'b0000, 10, 9, 2'b01, 99);
    sendPacket(4'b0100, 3, 10, 2'b11, 99);
    drain("R10");

    // R11: stall with two words buffered
    outReady = 1'b0;
    sendPacket(4'b0000, 16, 11, 2'b00, 99);
    check(outValid == 1'b1, "R11", "outValid while stalled", outValid, 1);
    check(outData == expQ[0].data, "R11", "head word", outData, expQ[0].data);
    repeat (3) step(2'b00, 4'h0);
    check(outValid == 1'b1, "R11", "outValid held", outValid, 1);
    check(outData == expQ[0].data, "R11", "head word held", outData, expQ[0].data);
    check(ovfFlag == 1'b0, "R11", "no overflow with two words", ovfFlag, 0);
    outReady = 1'b1;
    drain("R11");

    // R12: six words into a four-deep buffer while stalled
    outReady = 1'b0;
    sendPacket(4'b0100, 48, 12, 2'b00, 4);
    check(ovfFlag == 1'b1, "R12", "ovfFlag after drop", ovfFlag, 1);
    repeat (3) step(2'b00, 4'h0);
    check(ovfFlag == 1'b1, "R12", "ovfFlag sticky", ovfFlag, 1);
    ovfClear = 1'b1;
    step(2'b00, 4'h0);
    ovfClear = 1'b0;
    check(ovfFlag == 1'b0, "R12", "ovfFlag cleared", ovfFlag, 0);
    outReady = 1'b1;
    drain("R12");
    // traffic after overflow is unaffected
    sendPacket(4'b0010, 7, 13, 2'b00, 99);
    drain("R12");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule